// File: doc/BRIEF.md
# Vector Lane Swizzle Unit

This block rearranges the words of one vector operand between the lanes of a SIMD datapath. Every lane carries one word. For each operation the unit picks, for every destination lane, one source lane according to a mode and an 8-bit control field. The same rule applies to all lanes at once, so two lanes never compete for a port. The supported patterns are a crossbar inside each quad, full reversal, mirroring inside each row, rotation over a row or the full vector, exchange at a power-of-two distance, broadcast of one lane, and broadcast of one lane of a row into the rows above it.

An execution mask selects which destination lanes take the permuted word. Lanes whose mask bit is clear take the previous destination word, which is supplied on a separate input. The result is registered: it appears one clock after the operation is presented, together with a valid flag.

Top module: `swz_top`

## Requirements
- R1: Mode 0 (quad crossbar): output lane i takes input lane 4*(i/4)+s, where s is ctrl bits [2p+1:2p] and p = i mod 4.
- R2: Mode 1 (reverse): output lane i takes input lane 63-i.
- R3: Mode 2 (row mirror): output lane i takes input lane 16*(i/16) + 15 - (i mod 16).
- R4: Mode 3 (rotate): k is ctrl[5:0]. When ctrl[6]=1, output lane i takes input lane (i+k) mod 64. When ctrl[6]=0, rotation stays inside each 16-lane row: the source is 16*(i/16) + ((i mod 16)+k) mod 16.
- R5: Mode 4 (swap): output lane i takes input lane i XOR g, where g = 1 << ctrl[1:0], giving 1, 2, 4 or 8.
- R6: Mode 5 (broadcast): every output lane takes input lane ctrl[5:0].
- R7: Mode 6 (row broadcast): let r = ctrl[5:4] and j = ctrl[3:0]. Lanes in rows above r take input lane 16*r+j. For lanes in rows r and below the source is out of range; those lanes output zero when the bound input is 1, and their own input word when it is 0.
- R8: A destination lane whose execution-mask bit is 0 outputs its old destination word. This holds in every mode.
- R9: An operation presented with inValid=1 at a clock edge drives outValid=1 and the result after that edge. With inValid=0, outValid is 0 after the edge and the result is unchanged. Mode 7 passes every lane through unchanged.
- R10: After reset, outValid is 0 and the result is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation present this cycle |
| mode | input | 3 | Swizzle pattern select |
| ctrlField | input | 8 | Pattern argument (selectors, amount, lane, granularity) |
| boundZero | input | 1 | Out-of-range source lanes output zero |
| execMask | input | 64 | Per-lane write enable |
| srcVec | input | 2048 | Source vector, lane i at bits [32i+31:32i] |
| oldDst | input | 2048 | Previous destination vector |
| outValid | output | 1 | Result valid |
| resVec | output | 2048 | Registered result vector |

## Verification
Every lane of the source vector is filled with a distinct random word. A wrong source index therefore shows up as a wrong word, and it cannot be hidden by equal data. Directed cases cover the edges of each mode: quad selectors set to identity and to reversal, a full-width rotate by 63 next to a row rotate by 17 (which must wrap as 1), all four swap distances, and row broadcast from the top row and from a middle row with the bound bit both set and clear. All-zero and random execution masks separate the mask path from the permutation. Random operations over every mode and control value then compare the whole 2048-bit result, and idle cycles between operations check that the result is held.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    MODE_QUAD   = 3'd0,
    MODE_REV    = 3'd1,
    MODE_MIRROR = 3'd2,
    MODE_ROT    = 3'd3,
    MODE_SWAP   = 3'd4,
    MODE_BCAST  = 3'd5,
    MODE_ROWBC  = 3'd6,
    MODE_IDENT  = 3'd7
  } swzMode_e;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic       load;
    logic       selQuad;
    logic       selRev;
    logic       selMirror;
    logic       selRot;
    logic       selSwap;
    logic       selBcast;
    logic       selRowBc;
    logic [7:0] arg;
    logic       boundZero;
  } swzStrb_t;

endpackage

// File: rtl/swz_ctrl.sv
module swz_ctrl
  import swz_pkg::*;
(
  input  logic       inValid,
  input  logic [2:0] mode,
  input  logic [7:0] ctrlField,
  input  logic       boundZero,
  output swzStrb_t   strb
);

  always_comb begin
    strb           = '0;
    strb.load      = inValid;
    strb.arg       = ctrlField;
    strb.boundZero = boundZero;
    unique case (swzMode_e'(mode))
      MODE_QUAD:   strb.selQuad   = 1'b1;
      MODE_REV:    strb.selRev    = 1'b1;
      MODE_MIRROR: strb.selMirror = 1'b1;
      MODE_ROT:    strb.selRot    = 1'b1;
      MODE_SWAP:   strb.selSwap   = 1'b1;
      MODE_BCAST:  strb.selBcast  = 1'b1;
      MODE_ROWBC:  strb.selRowBc  = 1'b1;
      default:     ;  // identity: no select strobe
    endcase
  end

endmodule

// File: rtl/swz_datapath.sv
module swz_datapath
  import swz_pkg::*;
#(
  parameter int LANES = 64,
  parameter int WORD  = 32,
  parameter int ROW   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  swzStrb_t               strb,
  input  logic [LANES-1:0]       execMask,
  input  logic [LANES*WORD-1:0]  srcVec,
  input  logic [LANES*WORD-1:0]  oldDst,
  output logic                   outValid,
  output logic [LANES*WORD-1:0]  resVec
);

  localparam int LIDX  = $clog2(LANES);
  localparam int RIDX  = $clog2(ROW);
  localparam int RBITS = LIDX - RIDX;
  localparam int VW    = LANES * WORD;

  logic [VW-1:0]    nextVec;
  logic [LIDX-1:0]  laneArg;
  logic [RBITS-1:0] rowArg;
  logic [RIDX-1:0]  inRowArg;
  logic             fullRot;

  assign laneArg  = strb.arg[LIDX-1:0];
  assign rowArg   = strb.arg[RIDX +: RBITS];
  assign inRowArg = strb.arg[RIDX-1:0];
  assign fullRot  = strb.arg[LIDX];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LIDX-1:0] ME = LIDX'(i);
    localparam int QPOS = i % 4;
    logic [LIDX-1:0] srcIdx;
    logic            srcOk;
    logic [WORD-1:0] picked;

    always_comb begin
      srcIdx = ME;
      srcOk  = 1'b1;
      if (strb.selQuad)
        srcIdx = {ME[LIDX-1:2], strb.arg[2*QPOS +: 2]};
      else if (strb.selRev)
        srcIdx = ~ME;
      else if (strb.selMirror)
        srcIdx = {ME[LIDX-1:RIDX], ~ME[RIDX-1:0]};
      else if (strb.selRot) begin
        if (fullRot) srcIdx = ME + laneArg;
        else         srcIdx = {ME[LIDX-1:RIDX], ME[RIDX-1:0] + laneArg[RIDX-1:0]};
      end
      else if (strb.selSwap)
        srcIdx = ME ^ (LIDX'(1) << strb.arg[1:0]);
      else if (strb.selBcast)
        srcIdx = laneArg;
      else if (strb.selRowBc) begin
        if (ME[LIDX-1:RIDX] > rowArg) srcIdx = {rowArg, inRowArg};
        else                          srcOk  = 1'b0;
      end
      if (srcOk)               picked = srcVec[srcIdx*WORD +: WORD];
      else if (strb.boundZero) picked = '0;
      else                     picked = srcVec[i*WORD +: WORD];
    end

    assign nextVec[i*WORD +: WORD] = execMask[i] ? picked : oldDst[i*WORD +: WORD];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      resVec   <= '0;
    end else begin
      outValid <= strb.load;
      if (strb.load) resVec <= nextVec;
    end
  end

  a_r9_valid_set: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> outValid);
  a_r9_valid_clear: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> (!outValid && $stable(resVec)));
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (strb.load && execMask == '0) |=> (resVec == $past(oldDst)));
  a_r2_reverse_ends: assert property (@(posedge clk) disable iff (rst)
    (strb.load && strb.selRev && execMask[0]) |=>
      (resVec[WORD-1:0] == $past(srcVec[VW-1 -: WORD])));
  a_r6_bcast_equal: assert property (@(posedge clk) disable iff (rst)
    (strb.load && strb.selBcast && (&execMask)) |=>
      (resVec == {LANES{resVec[WORD-1:0]}}));
  a_r7_bound_zero: assert property (@(posedge clk) disable iff (rst)
    (strb.load && strb.selRowBc && strb.boundZero && (&rowArg) && (&execMask)) |=>
      (resVec == '0));

endmodule

// File: rtl/swz_top.sv
module swz_top
  import swz_pkg::*;
#(
  parameter int LANES = 64,
  parameter int WORD  = 32,
  parameter int ROW   = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic [2:0]            mode,
  input  logic [7:0]            ctrlField,
  input  logic                  boundZero,
  input  logic [LANES-1:0]      execMask,
  input  logic [LANES*WORD-1:0] srcVec,
  input  logic [LANES*WORD-1:0] oldDst,
  output logic                  outValid,
  output logic [LANES*WORD-1:0] resVec
);

  swzStrb_t strb;

  swz_ctrl i_ctrl (
    .inValid   (inValid),
    .mode      (mode),
    .ctrlField (ctrlField),
    .boundZero (boundZero),
    .strb      (strb)
  );

  swz_datapath #(.LANES(LANES), .WORD(WORD), .ROW(ROW)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .execMask (execMask),
    .srcVec   (srcVec),
    .oldDst   (oldDst),
    .outValid (outValid),
    .resVec   (resVec)
  );

endmodule

// File: tb/test_swz_top.sv
`timescale 1ns/1ps
module test_swz_top;

  localparam int LANES = 64;
  localparam int WORD  = 32;
  localparam int VW    = LANES * WORD;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            inValid = 1'b0;
  logic [2:0]      mode = '0;
  logic [7:0]      ctrlField = '0;
  logic            boundZero = 1'b0;
  logic [LANES-1:0] execMask = '0;
  logic [VW-1:0]   srcVec = '0;
  logic [VW-1:0]   oldDst = '0;
  logic            outValid;
  logic [VW-1:0]   resVec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  swz_top i_swz_top (
    .clk(clk), .rst(rst), .inValid(inValid), .mode(mode), .ctrlField(ctrlField),
    .boundZero(boundZero), .execMask(execMask), .srcVec(srcVec), .oldDst(oldDst),
    .outValid(outValid), .resVec(resVec)
  );

  function automatic string tagOf(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [VW-1:0] model(input logic [2:0] m, input logic [7:0] c,
      input logic bz, input logic [LANES-1:0] mk, input logic [VW-1:0] s, input logic [VW-1:0] o);
    logic [VW-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      int src;
      bit ok;
      logic [WORD-1:0] w;
      ok = 1;
      src = i;
      case (m)
        3'd0: src = (i / 4) * 4 + ((int'(c) >> (2 * (i % 4))) & 3);
        3'd1: src = 63 - i;
        3'd2: src = (i / 16) * 16 + 15 - (i % 16);
        3'd3: if (c[6]) src = (i + int'(c[5:0])) % 64;
              else      src = (i / 16) * 16 + ((i % 16) + int'(c[3:0])) % 16;
        3'd4: src = i ^ (1 << c[1:0]);
        3'd5: src = int'(c[5:0]);
        3'd6: if (i / 16 > int'(c[5:4])) src = int'(c[5:4]) * 16 + int'(c[3:0]);
              else ok = 0;
        default: src = i;
      endcase
      if (ok)      w = s[src*WORD +: WORD];
      else if (bz) w = '0;
      else         w = s[i*WORD +: WORD];
      r[i*WORD +: WORD] = mk[i] ? w : o[i*WORD +: WORD];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] randVec();
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*WORD +: WORD] = $urandom();
    return v;
  endfunction

  task automatic cmpVec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      for (int i = 0; i < LANES; i++)
        if (act[i*WORD +: WORD] !== exp[i*WORD +: WORD]) begin
          $display("FAIL %s lane %0d actual %h expected %h", tag, i,
                   act[i*WORD +: WORD], exp[i*WORD +: WORD]);
          break;
        end
    end
  endtask

  task automatic cmpBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  // One operation, then one idle cycle to check the hold behaviour (R9)
  task automatic doOp(input logic [2:0] m, input logic [7:0] c, input logic bz,
                      input logic [LANES-1:0] mk);
    logic [VW-1:0] exp;
    @(negedge clk);
    mode = m; ctrlField = c; boundZero = bz; execMask = mk;
    srcVec = randVec(); oldDst = randVec(); inValid = 1'b1;
    exp = model(m, c, bz, mk, srcVec, oldDst);
    @(negedge clk);
    inValid = 1'b0;
    mode = 3'($urandom()); ctrlField = 8'($urandom()); srcVec = randVec();
    cmpBit("R9 outValid after op", outValid, 1'b1);
    cmpVec(tagOf(m), resVec, exp);
    @(negedge clk);
    cmpBit("R9 outValid idle", outValid, 1'b0);
    cmpVec("R9 hold while idle", resVec, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    cmpBit("R10 outValid reset", outValid, 1'b0);
    cmpVec("R10 result reset", resVec, '0);
    rst = 1'b0;
    @(negedge clk);
    cmpBit("R10 outValid after reset", outValid, 1'b0);
    cmpVec("R10 result after reset", resVec, '0);

    // Directed corners
    doOp(3'd0, 8'hE4, 1'b0, '1);  // R1 identity selectors
    doOp(3'd0, 8'h1B, 1'b0, '1);  // R1 reverse inside quad
    doOp(3'd1, 8'h00, 1'b0, '1);  // R2
    doOp(3'd2, 8'h00, 1'b0, '1);  // R3
    doOp(3'd3, 8'h7F, 1'b0, '1);  // R4 full rotate by 63
    doOp(3'd3, 8'h11, 1'b0, '1);  // R4 row rotate by 17 -> 1
    for (int g = 0; g < 4; g++) doOp(3'd4, 8'(g), 1'b0, '1);  // R5 all distances
    doOp(3'd5, 8'h3F, 1'b0, '1);  // R6 top lane
    doOp(3'd6, 8'h35, 1'b1, '1);  // R7 top row, bound zero -> all zero
    doOp(3'd6, 8'h1A, 1'b1, '1);  // R7 row 1, bound zero
    doOp(3'd6, 8'h1A, 1'b0, '1);  // R7 row 1, pass-through
    doOp(3'd7, 8'hA5, 1'b0, '1);  // R9 identity mode
    doOp(3'd1, 8'h00, 1'b0, '0);  // R8 all lanes masked
    doOp(3'd3, 8'h45, 1'b0, 64'hF0F0_1234_8000_0001);  // R8 partial mask

    // Constrained random
    for (int n = 0; n < 300; n++) begin
      logic [LANES-1:0] mk;
      mk = {$urandom(), $urandom()};
      if (n % 5 == 0) mk = '1;
      doOp(3'($urandom()), 8'($urandom()), 1'($urandom()), mk);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule